// File: doc/BRIEF.md
# Voltage Reference Sequencer with Slew Limiting

This block produces the digital voltage targets for a core supply rail and an auxiliary supply rail. When the enable input rises while power-on-reset is valid, the block samples pin one of the six-pin code bus. That sample chooses between a parallel-code mode and a serial-code mode, and the choice holds until the block is disabled. In parallel mode the six pins form a 6-bit code for the core rail, and the auxiliary rail stays off. In serial mode the setpoint comes from one of three sources:

- a boot pair taken from two of the bus pins while the power-ok input is low;
- a debug fixed-voltage pair while the fixed-voltage input is high;
- 7-bit codes delivered over a valid/ready command port once power-ok is high.

Targets are unsigned integers in units of 0.5 mV. Neither output jumps to a new value. Each moves toward its setpoint by one unit per slew tick, and the ticks come from a clock divider. The tick divider is chosen so that the ramp is about 3.25 mV/us, which is 6.5 units per microsecond.

The command port is a single-beat valid/ready interface. `cmd_ready` is high only while a command can take effect. A command presented while `cmd_ready` is low is neither consumed nor lost: the sender keeps `cmd_valid` and the payload steady until a cycle in which both are high. A command is accepted on the clock edge where `cmd_valid` and `cmd_ready` are both high.

Top module: `vid_ref_seq`

## Requirements
- R1: After reset, and whenever the block is not running, both targets read 0, both off flags read 1, `running` reads 0 and `cmd_ready` reads 0.
- R2: On a rising edge of `en` sampled while `por_ok` is high, the block starts running. It selects parallel mode if `vid[1]` is 1 and serial mode (`mode_serial`=1) if `vid[1]` is 0. Later changes of `vid[1]` leave the mode unchanged until the block is disabled.
- R3: In parallel mode, a code with `vid[5]`=0 sets a core setpoint of 3100 - 50*`vid[4:0]` units.
- R4: In parallel mode, a code with `vid[5]`=1 sets a core setpoint of 1525 - 25*`vid[4:0]` units.
- R5: In parallel mode, the following hold regardless of `pwrok` and of any command offered:
  - the auxiliary rail is off with target 0;
  - `core_off` is 0;
  - `cmd_ready` is 0.
- R6: In serial mode with `vfixen`=0 and `pwrok`=0, the pair {`vid[3]`,`vid[2]`} sets both setpoints. The mapping is 00→2200, 01→2000, 10→1800 and 11→1600 units. The setpoints follow the pins while this condition lasts.
- R7: In serial mode with `vfixen`=1, whatever the level of `pwrok`, the same pair sets both setpoints. The mapping is 00→2800, 01→2400, 10→2000 and 11→1600 units. The setpoints follow changes on the pins.
- R8: Once `pwrok` rises in serial mode, each rail keeps the last boot selection until a command arrives. An accepted command writes `cmd_code` to the core rail if `cmd_core`=1, and to the auxiliary rail if `cmd_aux`=1. The new setpoint is 3100 - 25*`cmd_code` units.
- R9: Serial codes 0x7C to 0x7F turn the addressed rail off. Its off flag goes to 1 and its target ramps down to 0.
- R10: A target changes by at most one unit per slew tick. A tick occurs every `TICK_DIV` cycles while running. After enable, the targets soft-start from 0.
- R11: `cmd_ready` is 1 only when the block runs in serial mode with `pwrok`=1 and `vfixen`=0. A command held with `cmd_ready`=0 is not applied until it is accepted.
- R12: Driving `en` or `por_ok` low stops the block. Two clock edges later both targets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; a rising edge starts the block |
| por_ok | input | 1 | Power-on-reset valid |
| pwrok | input | 1 | Processor power-ok; selects boot or command codes in serial mode |
| vfixen | input | 1 | Debug fixed-voltage mode select |
| vid | input | 6 | Code bus; bit 1 selects the mode, bits 3:2 form the serial-mode pair |
| cmd_valid | input | 1 | Serial command valid |
| cmd_ready | output | 1 | Serial command can be accepted |
| cmd_core | input | 1 | Command addresses the core rail |
| cmd_aux | input | 1 | Command addresses the auxiliary rail |
| cmd_code | input | 7 | Serial 7-bit code |
| core_tgt | output | 12 | Ramped core target, 0.5 mV units |
| aux_tgt | output | 12 | Ramped auxiliary target, 0.5 mV units |
| core_off | output | 1 | Core rail off |
| aux_off | output | 1 | Auxiliary rail off |
| mode_serial | output | 1 | Latched mode: 1 serial, 0 parallel |
| running | output | 1 | Block enabled and running |

## Verification
The bench builds the block with `TICK_DIV`=2 and the default 12-bit target width. With those values a ramp across the full 3100-unit range takes a few thousand cycles. That makes every setpoint, every off ramp and the soft-start reachable in one short run. The short divider also lets the bench bound the soft-start slope after a fixed number of cycles. Throughout the run, a monitor checks the one-unit step limit on every cycle.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;
  localparam int TOP_UNITS     = 3100;
  localparam int SER_STEP      = 25;
  localparam int PAR_STEP_HI   = 50;
  localparam int PAR_BASE_LO   = 1525;
  localparam int PAR_STEP_LO   = 25;
  localparam logic [6:0] SER_OFF_MIN = 7'h7C;

  // boot pair maps to serial codes 36, 44, 52, 60
  function automatic logic [6:0] boot_code(input logic [1:0] pair);
    return 7'd36 + {2'b00, pair, 3'b000};
  endfunction

  function automatic logic [6:0] fixed_code(input logic [1:0] pair);
    case (pair)
      2'd0:    return 7'd12;
      2'd1:    return 7'd28;
      2'd2:    return 7'd44;
      default: return 7'd60;
    endcase
  endfunction

  function automatic logic ser_off(input logic [6:0] c);
    return c >= SER_OFF_MIN;
  endfunction

  function automatic int ser_units(input logic [6:0] c);
    if (ser_off(c)) return 0;
    return TOP_UNITS - SER_STEP * int'(c);
  endfunction

  function automatic int par_units(input logic [5:0] c);
    if (!c[5]) return TOP_UNITS - PAR_STEP_HI * int'(c[4:0]);
    return PAR_BASE_LO - PAR_STEP_LO * int'(c[4:0]);
  endfunction
endpackage

// File: rtl/vid_tick_gen.sv
module vid_tick_gen #(
  parameter int DIV = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/vid_code_store.sv
module vid_code_store
  import vid_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic       mode_serial,
  input  logic       pwrok,
  input  logic       vfixen,
  input  logic [1:0] pair,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_core,
  input  logic       cmd_aux,
  input  logic [6:0] cmd_code,
  output logic [6:0] core_code,
  output logic [6:0] aux_code
);
  logic take;
  logic boot_load;

  assign cmd_ready = running && mode_serial && pwrok && !vfixen;
  assign take      = cmd_valid && cmd_ready;
  assign boot_load = running && mode_serial && !pwrok && !vfixen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_code <= SER_OFF_MIN;
      aux_code  <= SER_OFF_MIN;
    end else if (boot_load) begin
      core_code <= boot_code(pair);
      aux_code  <= boot_code(pair);
    end else if (take) begin
      if (cmd_core) core_code <= cmd_code;
      if (cmd_aux)  aux_code  <= cmd_code;
    end
  end

  // R8 R11
  hold_without_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running && mode_serial && pwrok && !vfixen && !cmd_valid)
      |-> ($stable(core_code) && $stable(aux_code)));
endmodule

// File: rtl/vid_setpoint_sel.sv
module vid_setpoint_sel
  import vid_seq_pkg::*;
#(
  parameter int TGT_W = 12
) (
  input  logic             running,
  input  logic             mode_serial,
  input  logic             pwrok,
  input  logic             vfixen,
  input  logic [5:0]       vid,
  input  logic [6:0]       core_code,
  input  logic [6:0]       aux_code,
  output logic [TGT_W-1:0] core_sp,
  output logic [TGT_W-1:0] aux_sp,
  output logic             core_off,
  output logic             aux_off
);
  logic [1:0] pair;
  logic [6:0] pin_code;

  assign pair = vid[3:2];

  always_comb begin
    pin_code = vfixen ? fixed_code(pair) : boot_code(pair);
    core_sp  = '0;
    aux_sp   = '0;
    core_off = 1'b1;
    aux_off  = 1'b1;
    if (running) begin
      if (!mode_serial) begin
        core_sp  = TGT_W'(par_units(vid));
        core_off = 1'b0;
      end else if (vfixen || !pwrok) begin
        core_sp  = TGT_W'(ser_units(pin_code));
        aux_sp   = TGT_W'(ser_units(pin_code));
        core_off = 1'b0;
        aux_off  = 1'b0;
      end else begin
        core_sp  = TGT_W'(ser_units(core_code));
        aux_sp   = TGT_W'(ser_units(aux_code));
        core_off = ser_off(core_code);
        aux_off  = ser_off(aux_code);
      end
    end
  end
endmodule

// File: rtl/vid_slew_ramp.sv
module vid_slew_ramp #(
  parameter int TGT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [TGT_W-1:0] setpoint,
  output logic [TGT_W-1:0] cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cur <= '0;
    else if (!run)                   cur <= '0;
    else if (tick && cur < setpoint) cur <= cur + 1'b1;
    else if (tick && cur > setpoint) cur <= cur - 1'b1;
  end

  // R10
  step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ((cur == $past(cur)) || (cur == $past(cur) + 1'b1) ||
                    (cur == $past(cur) - 1'b1)));

  // R10
  move_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(tick)) |-> $stable(cur));
endmodule

// File: rtl/vid_ref_seq.sv
module vid_ref_seq
  import vid_seq_pkg::*;
#(
  parameter int TICK_DIV = 31,
  parameter int TGT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             por_ok,
  input  logic             pwrok,
  input  logic             vfixen,
  input  logic [5:0]       vid,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_core,
  input  logic             cmd_aux,
  input  logic [6:0]       cmd_code,
  output logic [TGT_W-1:0] core_tgt,
  output logic [TGT_W-1:0] aux_tgt,
  output logic             core_off,
  output logic             aux_off,
  output logic             mode_serial,
  output logic             running
);
  localparam int NRAIL = 2;

  logic             en_q;
  logic             tick;
  logic [6:0]       core_code;
  logic [6:0]       aux_code;
  logic [TGT_W-1:0] sp  [NRAIL];
  logic [TGT_W-1:0] tgt [NRAIL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      running     <= 1'b0;
      mode_serial <= 1'b0;
    end else begin
      en_q <= en;
      if (!en || !por_ok) begin
        running <= 1'b0;
      end else if (!en_q) begin
        running     <= 1'b1;
        mode_serial <= ~vid[1];
      end
    end
  end

  vid_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(running), .tick(tick)
  );

  vid_code_store u_store (
    .clk(clk), .rst_n(rst_n), .running(running), .mode_serial(mode_serial),
    .pwrok(pwrok), .vfixen(vfixen), .pair(vid[3:2]),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_core(cmd_core),
    .cmd_aux(cmd_aux), .cmd_code(cmd_code),
    .core_code(core_code), .aux_code(aux_code)
  );

  vid_setpoint_sel #(.TGT_W(TGT_W)) u_sel (
    .running(running), .mode_serial(mode_serial), .pwrok(pwrok),
    .vfixen(vfixen), .vid(vid), .core_code(core_code), .aux_code(aux_code),
    .core_sp(sp[0]), .aux_sp(sp[1]), .core_off(core_off), .aux_off(aux_off)
  );

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    vid_slew_ramp #(.TGT_W(TGT_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .run(running), .tick(tick),
      .setpoint(sp[g]), .cur(tgt[g])
    );
  end

  assign core_tgt = tgt[0];
  assign aux_tgt  = tgt[1];

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(mode_serial));

  // R5
  par_aux_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !mode_serial) |-> (aux_tgt == '0 && !cmd_ready));

  // R12
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ##1 (core_tgt == '0 && aux_tgt == '0));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (core_off && aux_off && !cmd_ready));
endmodule

// File: tb/tb_vid_ref_seq.sv
module tb_vid_ref_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, por_ok = 1'b0, pwrok = 1'b0, vfixen = 1'b0;
  logic [5:0]  vid = '0;
  logic        cmd_valid = 1'b0, cmd_core = 1'b0, cmd_aux = 1'b0;
  logic [6:0]  cmd_code = '0;
  logic        cmd_ready, core_off, aux_off, mode_serial, running;
  logic [11:0] core_tgt, aux_tgt;

  always #2.5 clk = ~clk;

  vid_ref_seq #(.TICK_DIV(2), .TGT_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .por_ok(por_ok), .pwrok(pwrok),
    .vfixen(vfixen), .vid(vid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_core(cmd_core), .cmd_aux(cmd_aux), .cmd_code(cmd_code),
    .core_tgt(core_tgt), .aux_tgt(aux_tgt), .core_off(core_off),
    .aux_off(aux_off), .mode_serial(mode_serial), .running(running)
  );

  typedef struct {
    int    core;
    int    aux;
    bit    coff;
    bit    aoff;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   done_cnt = 0;
  int   slew_bad = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard
  task automatic expect_out(input int c, input int a, input bit co, input bit ao,
                            input string tag);
    exp_t e;
    int   target;
    e.core = c; e.aux = a; e.coff = co; e.aoff = ao; e.tag = tag;
    target = done_cnt + 1;
    q.push_back(e);
    wait (done_cnt == target);
  endtask

  // monitor side of the scoreboard
  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if (int'(core_tgt) == e.core && int'(aux_tgt) == e.aux) break;
      end
      repeat (3) @(negedge clk);
      chk(int'(core_tgt) == e.core, {e.tag, " core_tgt"}, core_tgt, e.core);
      chk(int'(aux_tgt) == e.aux, {e.tag, " aux_tgt"}, aux_tgt, e.aux);
      chk(core_off == e.coff, {e.tag, " core_off"}, core_off, e.coff);
      chk(aux_off == e.aoff, {e.tag, " aux_off"}, aux_off, e.aoff);
      done_cnt++;
    end
  end

  // R10 step monitor
  logic [11:0] prev_c = '0, prev_a = '0;
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (int'(core_tgt) - int'(prev_c) > 1 || int'(prev_c) - int'(core_tgt) > 1) slew_bad++;
      if (int'(aux_tgt) - int'(prev_a) > 1 || int'(prev_a) - int'(aux_tgt) > 1) slew_bad++;
    end
    prev_c <= core_tgt;
    prev_a <= aux_tgt;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    por_ok = 1'b1;
    step(2);
    @(negedge clk);
    // R1
    chk(core_tgt == 0 && aux_tgt == 0, "R1 targets zero", core_tgt, 0);
    chk(core_off && aux_off && !running && !cmd_ready, "R1 idle flags",
        {core_off, aux_off, running, cmd_ready}, 4'b1100);

    // R2 parallel mode (vid[1]=1), code 2 -> R3 3000
    step(1);
    vid = 6'b000010;
    en = 1'b1;
    step(50);
    @(negedge clk);
    chk(core_tgt >= 20 && core_tgt <= 28, "R10 soft-start slope", core_tgt, 24);
    chk(running && !mode_serial, "R2 parallel latched", mode_serial, 0);
    expect_out(3000, 0, 0, 1, "R3 code2");

    // R2 mode held when vid[1] drops; R4 code 33 -> 1500
    step(1);
    vid = 6'b100001;
    expect_out(1500, 0, 0, 1, "R4 code33");
    chk(!mode_serial, "R2 mode held", mode_serial, 0);

    step(1);
    vid = 6'b011111;
    expect_out(1550, 0, 0, 1, "R3 code31");

    // R5 pwrok and commands ignored in parallel mode
    step(1);
    pwrok = 1'b1;
    cmd_valid = 1'b1; cmd_core = 1'b1; cmd_aux = 1'b1; cmd_code = 7'd0;
    step(3);
    @(negedge clk);
    chk(!cmd_ready, "R5 ready low in parallel", cmd_ready, 0);
    expect_out(1550, 0, 0, 1, "R5 parallel ignores pwrok/cmd");
    step(1);
    cmd_valid = 1'b0;
    pwrok = 1'b0;
    vid = 6'b111111;
    expect_out(750, 0, 0, 1, "R4 code63");

    // R12 disable
    step(1);
    en = 1'b0;
    step(2);
    @(negedge clk);
    chk(core_tgt == 0 && !running, "R12 disable clears", core_tgt, 0);

    // serial mode: vid[1]=0, pair {vid3,vid2}=01 -> R6 2000
    step(1);
    vid = 6'b000100;
    en = 1'b1;
    step(2);
    @(negedge clk);
    chk(mode_serial, "R2 serial latched", mode_serial, 1);
    expect_out(2000, 2000, 0, 0, "R6 boot 01");
    step(1);
    vid = 6'b001100;
    expect_out(1600, 1600, 0, 0, "R6 boot 11");

    // R7 fixed-voltage mode
    step(1);
    vfixen = 1'b1;
    vid = 6'b000000;
    expect_out(2800, 2800, 0, 0, "R7 fixed 00");
    step(1);
    pwrok = 1'b1;
    vid = 6'b001000;
    expect_out(2000, 2000, 0, 0, "R7 fixed 10 pwrok high");
    chk(!cmd_ready, "R11 ready low in fixed mode", cmd_ready, 0);

    // back to boot, then pwrok rises: hold boot selection (R8)
    step(1);
    pwrok = 1'b0;
    vfixen = 1'b0;
    expect_out(1800, 1800, 0, 0, "R6 boot 10");
    step(1);
    pwrok = 1'b1;
    expect_out(1800, 1800, 0, 0, "R8 boot held after pwrok");

    // R11 back-pressure: command waits while pwrok low
    step(1);
    pwrok = 1'b0;
    cmd_valid = 1'b1; cmd_core = 1'b1; cmd_aux = 1'b0; cmd_code = 7'h10;
    step(2);
    @(negedge clk);
    chk(!cmd_ready, "R11 ready low with pwrok low", cmd_ready, 0);
    expect_out(1800, 1800, 0, 0, "R11 command not applied");
    step(1);
    pwrok = 1'b1;
    step(1);
    cmd_valid = 1'b0;
    expect_out(2700, 1800, 0, 0, "R8 core-only command");

    // R9 off code to both rails
    step(1);
    cmd_valid = 1'b1; cmd_core = 1'b1; cmd_aux = 1'b1; cmd_code = 7'h7C;
    step(1);
    cmd_valid = 1'b0;
    expect_out(0, 0, 1, 1, "R9 off code");

    // R8 aux-only, smallest on code
    step(1);
    cmd_valid = 1'b1; cmd_core = 1'b0; cmd_aux = 1'b1; cmd_code = 7'h7B;
    step(1);
    cmd_valid = 1'b0;
    expect_out(0, 25, 1, 0, "R8 aux-only code 0x7B");

    // R12 por drop
    step(1);
    por_ok = 1'b0;
    step(2);
    @(negedge clk);
    chk(aux_tgt == 0 && core_off && aux_off, "R12 por drop", aux_tgt, 0);

    chk(slew_bad == 0, "R10 one unit per step", slew_bad, 0);
    summary();
  end
endmodule